// File: doc/BRIEF.md
# Link-Layer Replay Buffer Controller

This block forms the transmit half of a reliable link layer. Every packet the upper layer hands over through a ready/valid handshake is given a 12-bit sequence number. A copy is stored in a small circular replay store, and the packet is forwarded one cycle later. The far end answers with acknowledge events, which free every stored copy up to the sequence they carry. It can also answer with negative-acknowledge events, which free the copies up to that sequence and then resend everything still stored, oldest first.

A replay timer covers lost acknowledgements. When it expires, every unacknowledged packet is resent. Its limit depends on the lane count the link actually trained to. A 2-bit counter tracks replays that happen without forward progress. When another replay would overflow this counter, the block raises a retrain request instead of replaying. When the link drops, the block discards all of its state, so the first packet after the link comes back carries sequence 0.

Top module: `replay_tx_ctrl`

## Requirements
- R1: After the link comes up, the first accepted packet carries sequence 0, and each later new packet carries the previous sequence plus one. A packet accepted on a clock edge appears on the output on the next edge, with its sequence number and unchanged payload.
- R2: The upper-layer ready signal is low while DEPTH packets are unacknowledged. It returns high once an acknowledge retires at least one of them.
- R3: An acknowledge with sequence S retires every stored packet up to and including S. An acknowledge or negative acknowledge is ignored if S, measured modulo 4096 from the last acknowledged sequence, lies beyond the last sent sequence.
- R4: A negative acknowledge with sequence S retires packets up to S. From the next edge, the block resends the remaining packets one per cycle in their original order. No new packet is accepted until that replay is complete.
- R5: An acknowledge that arrives during a replay is processed at once. Packets it retires that have not yet been resent are skipped.
- R6: When packets are outstanding and nothing retires them, a replay starts after REPLAY_BASE >> link_width cycles. The link_width encoding is 0 = one lane, 1 = two, 2 = four, 3 = eight. The first resent copy appears (REPLAY_BASE >> link_width) + 1 cycles after the original transmission into an empty store.
- R7: Up to three replays in a row are allowed without any retirement. The fourth trigger raises retrain instead of replaying. retrain then blocks all traffic until the link goes down. Any retirement clears the count.
- R8: While link_up is low, ready and out_valid are low and offered packets are dropped. All sequence, replay and timer state, and the stored packets, are discarded.
- R9: Sequence numbers wrap from 4095 to 0, and acknowledges across the wrap retire correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link is operational; low discards all state |
| link_width | input | 2 | Trained lane count code (0:x1, 1:x2, 2:x4, 3:x8) |
| in_valid | input | 1 | Upper layer offers a packet |
| in_data | input | DW | Offered packet payload |
| in_ready | output | 1 | Block takes the offered packet on this edge |
| out_valid | output | 1 | A tagged packet is on the output this cycle |
| out_data | output | DW | Output packet payload |
| out_seq | output | SEQW | Output packet sequence number |
| dl_valid | input | 1 | An acknowledge event is present |
| dl_nak | input | 1 | The event is a negative acknowledge |
| dl_seq | input | SEQW | Sequence number carried by the event |
| retrain | output | 1 | Replay limit exceeded; link retrain requested |

## Verification
The bound checker runs on every cycle. It checks that each accepted packet leaves on the next edge with the sequence a reference counter predicts, so a resent packet can never collide with new traffic. It also checks that the output stays silent while the link is down and once retrain is raised. Only the directed scenarios can show the rest:
- the order of a replay and the skipping of entries acknowledged in the middle of one;
- the exact timer lengths for each lane code;
- the clearing of the replay count by forward progress;
- the discarding of old entries across a link drop;
- the wrap of the sequence space.

// File: rtl/replay_tx_ctrl.sv
module replay_tx_ctrl #(
  parameter int DW          = 16,
  parameter int DEPTH       = 8,
  parameter int SEQW        = 12,
  parameter int REPLAY_BASE = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_up,
  input  logic [1:0]      link_width,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            in_ready,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic [SEQW-1:0] out_seq,
  input  logic            dl_valid,
  input  logic            dl_nak,
  input  logic [SEQW-1:0] dl_seq,
  output logic            retrain
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(REPLAY_BASE + 1);
  localparam logic [SEQW-1:0] ONE = SEQW'(1);

  logic [DW-1:0]   mem [DEPTH];
  logic [SEQW-1:0] next_seq, ackd_seq, rp_seq;
  logic            replaying;
  logic [1:0]      replay_num;
  logic [TW-1:0]   timer;

  logic [SEQW-1:0] outstanding, dl_off, ackd_n, left_n, rp_off, rp_cur;
  logic [TW-1:0]   lim;
  logic [1:0]      num_base;
  logic            dl_ok, retire, timing, expire, trigger, roll, accept, send_rp;

  assign outstanding = next_seq - ackd_seq - ONE;
  assign dl_off      = dl_seq - ackd_seq;
  assign dl_ok       = dl_valid && (dl_off <= outstanding);
  assign retire      = dl_ok && (dl_off != '0);
  assign ackd_n      = retire ? dl_seq : ackd_seq;
  assign left_n      = next_seq - ackd_n - ONE;
  assign rp_off      = rp_seq - ackd_seq;
  assign rp_cur      = (retire && (dl_off >= rp_off)) ? dl_seq + ONE : rp_seq;

  assign lim     = TW'(REPLAY_BASE >> link_width);
  assign timing  = (outstanding != '0) && !replaying && !retrain;
  assign expire  = timing && !retire && (timer >= lim - TW'(1));
  assign trigger = ((dl_ok && dl_nak) || expire) && (left_n != '0) && !retrain;

  assign num_base = retire ? 2'd0 : replay_num;
  assign roll     = trigger && (num_base == 2'd3);

  assign in_ready = link_up && !replaying && !retrain && (outstanding < SEQW'(DEPTH));
  assign accept   = in_valid && in_ready;
  assign send_rp  = replaying && !trigger && (rp_cur != next_seq);

  always_ff @(posedge clk) begin
    if (accept) mem[next_seq[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_seq   <= '0;
      ackd_seq   <= '1;
      rp_seq     <= '0;
      replaying  <= 1'b0;
      replay_num <= 2'd0;
      timer      <= '0;
      retrain    <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_seq    <= '0;
    end else if (!link_up) begin
      next_seq   <= '0;
      ackd_seq   <= '1;
      rp_seq     <= '0;
      replaying  <= 1'b0;
      replay_num <= 2'd0;
      timer      <= '0;
      retrain    <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_seq    <= '0;
    end else begin
      ackd_seq   <= ackd_n;
      replay_num <= (trigger && !roll) ? num_base + 2'd1 : num_base;
      if (accept) next_seq <= next_seq + ONE;
      if (roll) retrain <= 1'b1;

      if (roll) begin
        replaying <= 1'b0;
      end else if (trigger) begin
        replaying <= 1'b1;
        rp_seq    <= ackd_n + ONE;
      end else if (replaying) begin
        if (rp_cur == next_seq) replaying <= 1'b0;
        else                    rp_seq    <= rp_cur + ONE;
      end

      if (!timing || retire || trigger) timer <= '0;
      else                              timer <= timer + TW'(1);

      out_valid <= accept || send_rp;
      out_data  <= accept ? in_data  : mem[rp_cur[AW-1:0]];
      out_seq   <= accept ? next_seq : rp_cur;
    end
  end
endmodule

// File: rtl/replay_tx_ctrl_chk.sv
module replay_tx_ctrl_chk #(
  parameter int DW   = 16,
  parameter int SEQW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            link_up,
  input logic            in_valid,
  input logic            in_ready,
  input logic [DW-1:0]   in_data,
  input logic            out_valid,
  input logic [DW-1:0]   out_data,
  input logic [SEQW-1:0] out_seq,
  input logic            retrain
);
  logic [SEQW-1:0] exp_seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     exp_seq <= '0;
    else if (!link_up)              exp_seq <= '0;
    else if (in_valid && in_ready)  exp_seq <= exp_seq + SEQW'(1);
  end

  // R1
  new_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_seq == $past(exp_seq)));

  // R4
  no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data == $past(in_data)));

  // R8
  link_down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> !out_valid);

  // R7
  retrain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> !out_valid);
endmodule

bind replay_tx_ctrl replay_tx_ctrl_chk #(.DW(DW), .SEQW(SEQW)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .in_valid(in_valid),
  .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
  .out_data(out_data), .out_seq(out_seq), .retrain(retrain)
);

// File: tb/replay_tx_ctrl_tb.sv
`timescale 1ns/1ps
module replay_tx_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic [1:0]  link_width = 2'd0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic [11:0] out_seq;
  logic        dl_valid = 1'b0;
  logic        dl_nak = 1'b0;
  logic [11:0] dl_seq = '0;
  logic        retrain;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [11:0] lseq[$];
  logic [15:0] ldat[$];
  int          lcyc[$];

  replay_tx_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .link_width(link_width),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_seq(out_seq),
    .dl_valid(dl_valid), .dl_nak(dl_nak), .dl_seq(dl_seq), .retrain(retrain)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (out_valid) begin
    lseq.push_back(out_seq); ldat.push_back(out_data); lcyc.push_back(cyc);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    lseq.delete(); ldat.delete(); lcyc.delete();
  endtask

  task automatic link_cycle();
    @(negedge clk); link_up = 1'b0;
    repeat (2) @(negedge clk);
    link_up = 1'b1;
    lseq.delete(); ldat.delete(); lcyc.delete();
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic dl(input bit nak, input int s);
    @(negedge clk); dl_valid = 1'b1; dl_nak = nak; dl_seq = s[11:0];
    @(negedge clk); dl_valid = 1'b0; dl_nak = 1'b0;
  endtask

  task automatic wait_log(input int n, input int max);
    for (int k = 0; k < max && lseq.size() < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R8", "ready while down", int'(in_ready), 0);
    chk("R8", "out_valid while down", int'(out_valid), 0);
    chk("R7", "retrain at reset", int'(retrain), 0);
    link_up = 1'b1;
    @(negedge clk);
    chk("R8", "ready after link up", int'(in_ready), 1);
  endtask

  task automatic t_basic();
    link_cycle();
    for (int i = 0; i < 3; i++) send(16'hA0 + 16'(i));
    wait_log(3, 5);
    chk("R1", "basic count", lseq.size(), 3);
    if (lseq.size() == 3)
      for (int i = 0; i < 3; i++) begin
        chk("R1", "basic seq", int'(lseq[i]), i);
        chk("R1", "basic data", int'(ldat[i]), 'hA0 + i);
      end
    dl(0, 2);
  endtask

  task automatic t_full();
    link_cycle();
    for (int i = 0; i < 8; i++) send(16'h30 + 16'(i));
    chk("R2", "ready when full", int'(in_ready), 0);
    dl(0, 20);
    chk("R3", "out-of-window ack ignored", int'(in_ready), 0);
    clear_log();
    dl(1, 20);
    repeat (5) @(negedge clk);
    chk("R3", "out-of-window nak no replay", lseq.size(), 0);
    dl(0, 2);
    chk("R2", "ready after retire", int'(in_ready), 1);
    dl(0, 7);
  endtask

  task automatic t_nak();
    link_cycle();
    for (int i = 0; i < 5; i++) send(16'h10 + 16'(i));
    clear_log();
    dl(1, 1);
    chk("R4", "ready low in replay", int'(in_ready), 0);
    send(16'hEE);
    wait_log(4, 10);
    chk("R4", "nak log count", lseq.size(), 4);
    if (lseq.size() == 4) begin
      chk("R4", "replay seq a", int'(lseq[0]), 2);
      chk("R4", "replay seq b", int'(lseq[1]), 3);
      chk("R4", "replay seq c", int'(lseq[2]), 4);
      chk("R4", "replay data c", int'(ldat[2]), 'h14);
      chk("R4", "new after replay seq", int'(lseq[3]), 5);
      chk("R4", "new after replay data", int'(ldat[3]), 'hEE);
    end
    dl(0, 5);
  endtask

  task automatic t_ack_mid();
    link_cycle();
    for (int i = 0; i < 6; i++) send(16'h40 + 16'(i));
    clear_log();
    dl(1, 4095);
    dl(0, 3);
    wait_log(3, 10);
    repeat (5) @(negedge clk);
    chk("R5", "mid-replay log count", lseq.size(), 3);
    if (lseq.size() == 3) begin
      chk("R5", "first resent", int'(lseq[0]), 0);
      chk("R5", "skip to", int'(lseq[1]), 4);
      chk("R5", "last resent", int'(lseq[2]), 5);
    end
    dl(0, 5);
  endtask

  task automatic t_linkdown();
    link_cycle();
    for (int i = 0; i < 3; i++) send(16'h60 + 16'(i));
    @(negedge clk); link_up = 1'b0; in_valid = 1'b1; in_data = 16'h55;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", "ready while down", int'(in_ready), 0);
      chk("R8", "no output while down", int'(out_valid), 0);
    end
    in_valid = 1'b0; link_up = 1'b1;
    lseq.delete(); ldat.delete(); lcyc.delete();
    send(16'h77);
    repeat (70) @(negedge clk);
    chk("R8", "log after relink", lseq.size(), 2);
    if (lseq.size() == 2) begin
      chk("R8", "first seq after relink", int'(lseq[0]), 0);
      chk("R8", "replay holds only new", int'(lseq[1]), 0);
      chk("R8", "replay data", int'(ldat[1]), 'h77);
      chk("R6", "x1 timer span", lcyc[1] - lcyc[0], 65);
    end
    dl(0, 0);
  endtask

  task automatic t_timer();
    link_width = 2'd3;
    link_cycle();
    send(16'h81);
    wait_log(2, 30);
    chk("R6", "x8 timer span", (lseq.size() == 2) ? lcyc[1] - lcyc[0] : -1, 9);
    dl(0, 0);
    link_width = 2'd2;
    clear_log();
    send(16'h82);
    wait_log(2, 40);
    chk("R6", "x4 timer span", (lseq.size() == 2) ? lcyc[1] - lcyc[0] : -1, 17);
    dl(0, 1);
  endtask

  task automatic t_retrain();
    link_width = 2'd3;
    link_cycle();
    send(16'h91);
    send(16'h92);
    wait_log(8, 200);
    chk("R7", "three replays", lseq.size(), 8);
    dl(0, 0);
    wait_log(9, 40);
    chk("R7", "progress clears count", int'(retrain), 0);
    chk("R7", "replay after progress", (lseq.size() >= 9) ? int'(lseq[8]) : -1, 1);
    for (int k = 0; k < 200 && !retrain; k++) @(negedge clk);
    chk("R7", "retrain raised", int'(retrain), 1);
    chk("R7", "replays before retrain", lseq.size(), 11);
    chk("R7", "ready in retrain", int'(in_ready), 0);
    repeat (20) @(negedge clk);
    chk("R7", "silent in retrain", lseq.size(), 11);
    link_cycle();
    @(negedge clk);
    chk("R7", "retrain cleared by link down", int'(retrain), 0);
    chk("R7", "ready after relink", int'(in_ready), 1);
    link_width = 2'd0;
  endtask

  task automatic t_wrap();
    int bad = 0;
    link_cycle();
    for (int i = 0; i < 4100; i++) begin
      send(16'(i));
      dl(0, i % 4096);
      if (lseq.size() != 1 || int'(lseq[0]) != i % 4096) bad++;
      if (i == 4095) chk("R9", "seq 4095", (lseq.size() == 1) ? int'(lseq[0]) : -1, 4095);
      if (i == 4096) chk("R9", "wrap to 0", (lseq.size() == 1) ? int'(lseq[0]) : -1, 0);
      lseq.delete(); ldat.delete(); lcyc.delete();
    end
    chk("R9", "wrap mismatches", bad, 0);
    chk("R9", "drained after wrap", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_full();
    t_nak();
    t_ack_mid();
    t_linkdown();
    t_timer();
    t_retrain();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule